// File: doc/BRIEF.md
# Timestamped Hit Channel Buffer

This block sits behind one channel of a time-to-digital front end. It accepts a stream of 40-bit words. Some words are coarse time markers and the others are hit words. A marker sets the time reference for the hits that follow it. The marker is stored in the channel and never reaches the output.

Each accepted hit is turned at once into a compact 22-bit record. The record holds the channel number and a fine time, which is the hit time measured from the most recent marker. The record is queued in a small FIFO. An output state machine moves queued records into an output register and shows them with a valid/ready handshake. A single parameter picks the variant: the high-threshold variant has an 8-entry queue and the low-threshold variant has a 16-entry queue.

Faults are kept in two sticky flags. One reports a hit that arrived before any marker. The other reports a word pushed while the block could not accept it. Both flags clear only on reset.

Top module: `hit_chan_buf`

## Requirements
- R1: Bit 39 of an input word selects its kind: 1 means a marker and 0 means a hit. Bits 21:0 carry the time, and bits 38:22 are ignored. A marker never produces an output record.
- R2: An output record has the channel number (parameter CHANNEL) in bits 21:16. Bits 15:0 hold the fine time, which is the low 16 bits of (hit time − latest marker time) computed modulo 2^22.
- R3: A hit accepted before any marker since reset is dropped, produces no record, and sets `err_no_marker`. That flag stays set until reset.
- R4: The queue depth is 8 when HIGH_THR=1 and 16 when HIGH_THR=0. Together with the output register, the block holds DEPTH+1 records. `wr_ready` is low exactly while the queue is full.
- R5: A push while `wr_ready` is low is discarded and sets `overflow`. That flag stays set until reset.
- R6: Records leave in the order in which their hits were accepted. Each record uses the marker that was latest when its hit arrived.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_rec` does not change.
- R8: `empty` is high exactly when the block holds no record, either queued or presented.
- R9: After reset, `empty` is 1, `wr_ready` is 1, and `out_valid`, `err_no_marker` and `overflow` are 0.
- R10: When the queue and the output register are idle, a hit pushed at clock edge k is presented with `out_valid` high after edge k+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_data | input | 40 | Input word, either a marker or a hit |
| wr_push | input | 1 | Input word is present this cycle |
| wr_ready | output | 1 | Block can accept a word |
| out_rec | output | 22 | Hit record: channel number and fine time |
| out_valid | output | 1 | `out_rec` holds a record |
| out_ready | input | 1 | Consumer takes the presented record |
| empty | output | 1 | No record is held |
| err_no_marker | output | 1 | Sticky: a hit arrived before any marker |
| overflow | output | 1 | Sticky: a push was discarded |

## Verification
A wrong latched marker does not stay hidden. It shows in the fine-time field of the very next record, two edges after the hit is pushed. The sweep therefore pairs marker and hit times that cross the 2^16 and 2^22 wrap points. A queue pointer or count error shows up in several ways: records come out in the wrong order or are repeated, `wr_ready` drops at the wrong fill level, or `empty` disagrees with `out_valid`. A fill test runs both variants side by side and shows such an error within one drain.

// File: rtl/hitbuf_pkg.sv
package hitbuf_pkg;

    localparam int WORD_W   = 40;
    localparam int TIME_W   = 22;
    localparam int FINE_W   = 16;
    localparam int CHAN_W   = 6;
    localparam int REC_W    = CHAN_W + FINE_W;
    localparam int SPARE_W  = WORD_W - 1 - TIME_W;

    typedef logic [TIME_W-1:0] time_t;

    typedef enum logic {
        WK_HIT  = 1'b0,
        WK_MARK = 1'b1
    } word_kind_e;

    typedef struct packed {
        word_kind_e            kind;
        logic [SPARE_W-1:0]    spare;
        time_t                 t;
    } in_word_t;

    typedef struct packed {
        logic [CHAN_W-1:0]     chan;
        logic [FINE_W-1:0]     fine;
    } rec_t;

    function automatic logic [FINE_W-1:0] fine_delta(input time_t hit_t, input time_t mark_t);
        time_t diff;
        diff = hit_t - mark_t;
        return diff[FINE_W-1:0];
    endfunction

endpackage

// File: rtl/hitbuf_mark_track.sv
module hitbuf_mark_track
    import hitbuf_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  load,
    input  time_t time_in,
    output time_t mark_q,
    output logic  seen_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            mark_q <= '0;
            seen_q <= 1'b0;
        end else if (load) begin
            mark_q <= time_in;
            seen_q <= 1'b1;
        end
    end

endmodule

// File: rtl/hitbuf_fifo.sv
module hitbuf_fifo
    import hitbuf_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic wr_en,
    input  rec_t wr_rec,
    input  logic rd_en,
    output rec_t rd_rec,
    output logic full,
    output logic empty
);

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    rec_t          mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [CW-1:0] cnt;
    logic          do_wr, do_rd;

    function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
        return (p == LAST) ? '0 : p + 1'b1;
    endfunction

    assign full   = (cnt == CW'(DEPTH));
    assign empty  = (cnt == '0);
    assign do_wr  = wr_en && !full;
    assign do_rd  = rd_en && !empty;
    assign rd_rec = mem[rp];

    always_ff @(posedge clk) begin
        if (do_wr) mem[wp] <= wr_rec;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_wr) wp <= step(wp);
            if (do_rd) rp <= step(rp);
            case ({do_wr, do_rd})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

endmodule

// File: rtl/hitbuf_out_stage.sv
module hitbuf_out_stage
    import hitbuf_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic src_empty,
    input  rec_t src_rec,
    output logic pop,
    input  logic out_ready,
    output logic out_valid,
    output rec_t out_rec
);

    typedef enum logic {OS_IDLE, OS_HOLD} out_state_e;

    out_state_e state;

    assign pop       = !src_empty && (state == OS_IDLE || out_ready);
    assign out_valid = (state == OS_HOLD);

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= OS_IDLE;
            out_rec <= '0;
        end else if (pop) begin
            state   <= OS_HOLD;
            out_rec <= src_rec;
        end else if (out_ready) begin
            state   <= OS_IDLE;
        end
    end

endmodule

// File: rtl/hit_chan_buf.sv
module hit_chan_buf
    import hitbuf_pkg::*;
#(
    parameter bit HIGH_THR = 1'b1,
    parameter int CHANNEL  = 0,
    parameter int HI_DEPTH = 8,
    parameter int LO_DEPTH = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [WORD_W-1:0]   wr_data,
    input  logic                wr_push,
    output logic                wr_ready,
    output logic [REC_W-1:0]    out_rec,
    output logic                out_valid,
    input  logic                out_ready,
    output logic                empty,
    output logic                err_no_marker,
    output logic                overflow
);

    localparam int DEPTH = HIGH_THR ? HI_DEPTH : LO_DEPTH;
    localparam logic [CHAN_W-1:0] CHAN_ID = CHAN_W'(CHANNEL);

    in_word_t word;
    time_t    mark_q;
    logic     ts_seen;
    logic     accept, load_mark, hit_keep, hit_orphan;
    logic     q_full, q_empty, q_pop;
    rec_t     q_in, q_out, o_rec;
    logic     unused_spare;

    assign word         = in_word_t'(wr_data);
    assign unused_spare = ^word.spare;

    assign wr_ready   = !q_full;
    assign accept     = wr_push && wr_ready;
    assign load_mark  = accept && (word.kind == WK_MARK);
    assign hit_keep   = accept && (word.kind == WK_HIT) && ts_seen;
    assign hit_orphan = accept && (word.kind == WK_HIT) && !ts_seen;

    assign q_in.chan = CHAN_ID;
    assign q_in.fine = fine_delta(word.t, mark_q);

    hitbuf_mark_track u_mark (
        .clk     (clk),
        .rst     (rst),
        .load    (load_mark),
        .time_in (word.t),
        .mark_q  (mark_q),
        .seen_q  (ts_seen)
    );

    hitbuf_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (hit_keep),
        .wr_rec (q_in),
        .rd_en  (q_pop),
        .rd_rec (q_out),
        .full   (q_full),
        .empty  (q_empty)
    );

    hitbuf_out_stage u_out (
        .clk       (clk),
        .rst       (rst),
        .src_empty (q_empty),
        .src_rec   (q_out),
        .pop       (q_pop),
        .out_ready (out_ready),
        .out_valid (out_valid),
        .out_rec   (o_rec)
    );

    assign out_rec = o_rec;
    assign empty   = q_empty && !out_valid;

    always_ff @(posedge clk) begin
        if (rst) begin
            err_no_marker <= 1'b0;
            overflow      <= 1'b0;
        end else begin
            if (hit_orphan)          err_no_marker <= 1'b1;
            if (wr_push && !wr_ready) overflow      <= 1'b1;
        end
    end

endmodule

// File: rtl/hit_chan_buf_chk.sv
module hit_chan_buf_chk #(
    parameter int CHANNEL = 0
) (
    input logic        clk,
    input logic        rst,
    input logic        wr_push,
    input logic        wr_is_mark,
    input logic        wr_ready,
    input logic [21:0] out_rec,
    input logic        out_valid,
    input logic        out_ready,
    input logic        empty,
    input logic        err_no_marker,
    input logic        overflow,
    input logic        ts_seen
);

    localparam logic [5:0] CH = 6'(CHANNEL);

    assert_orphan_R3: assert property (@(posedge clk) disable iff (rst)
        wr_push && wr_ready && !wr_is_mark && !ts_seen |=> err_no_marker);

    assert_err_sticky_R3: assert property (@(posedge clk) disable iff (rst)
        err_no_marker |=> err_no_marker);

    assert_discard_R5: assert property (@(posedge clk) disable iff (rst)
        wr_push && !wr_ready |=> overflow);

    assert_ovf_sticky_R5: assert property (@(posedge clk) disable iff (rst)
        overflow |=> overflow);

    assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_rec));

    assert_empty_R8: assert property (@(posedge clk) disable iff (rst)
        empty |-> !out_valid);

    assert_chan_R2: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> out_rec[21:16] == CH);

endmodule

bind hit_chan_buf hit_chan_buf_chk #(.CHANNEL(CHANNEL)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .wr_push       (wr_push),
    .wr_is_mark    (wr_data[39]),
    .wr_ready      (wr_ready),
    .out_rec       (out_rec),
    .out_valid     (out_valid),
    .out_ready     (out_ready),
    .empty         (empty),
    .err_no_marker (err_no_marker),
    .overflow      (overflow),
    .ts_seen       (ts_seen)
);

// File: tb/hit_chan_buf_tb.sv
`timescale 1ns/1ps
module hit_chan_buf_tb;

    localparam int CH_HI = 5;
    localparam int CH_LO = 42;

    logic        clk = 1'b0;
    logic        rst;
    logic [39:0] wr_data;
    logic        wr_push, out_ready;
    logic        hi_ready, hi_valid, hi_empty, hi_err, hi_ovf;
    logic        lo_ready, lo_valid, lo_empty, lo_err, lo_ovf;
    logic [21:0] hi_rec, lo_rec;
    int          n_chk = 0, n_fail = 0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    hit_chan_buf #(.HIGH_THR(1'b1), .CHANNEL(CH_HI)) u_dut (
        .clk(clk), .rst(rst), .wr_data(wr_data), .wr_push(wr_push), .wr_ready(hi_ready),
        .out_rec(hi_rec), .out_valid(hi_valid), .out_ready(out_ready), .empty(hi_empty),
        .err_no_marker(hi_err), .overflow(hi_ovf));

    hit_chan_buf #(.HIGH_THR(1'b0), .CHANNEL(CH_LO)) u_dut_lo (
        .clk(clk), .rst(rst), .wr_data(wr_data), .wr_push(wr_push), .wr_ready(lo_ready),
        .out_rec(lo_rec), .out_valid(lo_valid), .out_ready(out_ready), .empty(lo_empty),
        .err_no_marker(lo_err), .overflow(lo_ovf));

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    function automatic logic [21:0] exp_rec(input int ch, input logic [21:0] hit_t, input logic [21:0] mark_t);
        logic [21:0] d;
        d = hit_t - mark_t;
        return {6'(ch), d[15:0]};
    endfunction

    function automatic logic [39:0] mark_w(input logic [21:0] t);
        return {1'b1, 17'h1A5A5, t};
    endfunction

    function automatic logic [39:0] hit_w(input logic [21:0] t);
        return {1'b0, 17'h0C3C3, t};
    endfunction

    task automatic push(input logic [39:0] w);
        wr_data = w;
        wr_push = 1'b1;
        @(negedge clk);
        wr_push = 1'b0;
    endtask

    // pop one record, checking lo always and hi when it should hold one
    task automatic pop_both(input logic [21:0] hit_t, input logic [21:0] mark_t, input bit hi_has, input string tag);
        for (int w = 0; w < 4 && !lo_valid; w++) @(negedge clk);
        chk(lo_valid, {tag, " lo valid"}, 64'(lo_valid), 64'd1);
        chk(lo_rec == exp_rec(CH_LO, hit_t, mark_t), {tag, " lo rec"}, 64'(lo_rec), 64'(exp_rec(CH_LO, hit_t, mark_t)));
        if (hi_has) begin
            chk(hi_valid, {tag, " hi valid"}, 64'(hi_valid), 64'd1);
            chk(hi_rec == exp_rec(CH_HI, hit_t, mark_t), {tag, " hi rec"}, 64'(hi_rec), 64'(exp_rec(CH_HI, hit_t, mark_t)));
        end else begin
            chk(!hi_valid && hi_empty, {tag, " hi drained"}, 64'({hi_valid, hi_empty}), 64'b01);
        end
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        logic [21:0] marks [4];
        logic [21:0] deltas [7];
        logic [21:0] base;
        rst = 1'b1; wr_push = 1'b0; out_ready = 1'b0; wr_data = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R9 reset state
        chk(hi_empty && lo_empty, "R9 empty", 64'({hi_empty, lo_empty}), 64'b11);
        chk(hi_ready && lo_ready && !hi_valid && !lo_valid, "R9 ready/valid",
            64'({hi_ready, lo_ready, hi_valid, lo_valid}), 64'b1100);
        chk(!hi_err && !lo_err && !hi_ovf && !lo_ovf, "R9 flags",
            64'({hi_err, lo_err, hi_ovf, lo_ovf}), 64'b0);

        // R3 hit before any marker
        push(hit_w(22'h55));
        @(negedge clk);
        chk(hi_err && lo_err, "R3 orphan flag", 64'({hi_err, lo_err}), 64'b11);
        chk(hi_empty && lo_empty && !lo_valid, "R3 orphan dropped", 64'({hi_empty, lo_empty, lo_valid}), 64'b110);

        // R1 marker makes no record
        push(mark_w(22'd100));
        @(negedge clk);
        chk(lo_empty && !lo_valid, "R1 marker no record", 64'({lo_empty, lo_valid}), 64'b10);

        // R10 latency
        push(hit_w(22'd107));
        chk(!lo_valid, "R10 not yet valid", 64'(lo_valid), 64'd0);
        @(negedge clk);
        chk(lo_valid && hi_valid, "R10 valid after two edges", 64'({lo_valid, hi_valid}), 64'b11);
        chk(hi_err && lo_err, "R3 sticky", 64'({hi_err, lo_err}), 64'b11);
        pop_both(22'd107, 22'd100, 1'b1, "R2 first");

        // R7 hold
        push(mark_w(22'h3000));
        push(hit_w(22'h3456));
        @(negedge clk);
        repeat (5) @(negedge clk);
        chk(lo_valid && lo_rec == exp_rec(CH_LO, 22'h3456, 22'h3000), "R7 hold",
            64'(lo_rec), 64'(exp_rec(CH_LO, 22'h3456, 22'h3000)));
        pop_both(22'h3456, 22'h3000, 1'b1, "R7 pop");

        // R2 sweep over marker/delta pairs including wraps
        marks  = '{22'h0, 22'h3FFFF0, 22'h1ABCDE, 22'h2FFFFF};
        deltas = '{22'h0, 22'h1, 22'hFFFF, 22'h10000, 22'h12345, 22'h3FFFFF, 22'h200000};
        foreach (marks[i]) begin
            foreach (deltas[j]) begin
                push(mark_w(marks[i]));
                push(hit_w(marks[i] + deltas[j]));
                pop_both(marks[i] + deltas[j], marks[i], 1'b1, "R2 sweep");
            end
        end

        // R6 ordering across markers
        push(mark_w(22'd1000));
        push(hit_w(22'd1003));
        push(hit_w(22'd1050));
        push(mark_w(22'd5000));
        push(hit_w(22'd4990));
        push(hit_w(22'd5001));
        pop_both(22'd1003, 22'd1000, 1'b1, "R6 order 0");
        pop_both(22'd1050, 22'd1000, 1'b1, "R6 order 1");
        pop_both(22'd4990, 22'd5000, 1'b1, "R6 order 2");
        pop_both(22'd5001, 22'd5000, 1'b1, "R6 order 3");
        chk(hi_empty && lo_empty, "R8 empty after drain", 64'({hi_empty, lo_empty}), 64'b11);

        // R4 / R5 fill both variants
        chk(!hi_ovf && !lo_ovf, "R5 no overflow yet", 64'({hi_ovf, lo_ovf}), 64'b0);
        base = 22'h20000;
        push(mark_w(base));
        for (int k = 0; k < 17; k++) begin
            push(hit_w(base + 22'(k * 257 + 1)));
            if (k == 7) chk(hi_ready, "R4 hi ready at 8", 64'(hi_ready), 64'd1);
            if (k == 8) chk(!hi_ready && lo_ready, "R4 hi full at 9",
                            64'({hi_ready, lo_ready}), 64'b01);
            if (k == 15) chk(lo_ready, "R4 lo ready at 16", 64'(lo_ready), 64'd1);
        end
        chk(!lo_ready, "R4 lo full at 17", 64'(lo_ready), 64'd0);
        chk(hi_ovf && !lo_ovf, "R5 hi overflow only", 64'({hi_ovf, lo_ovf}), 64'b10);
        chk(!hi_empty && !lo_empty, "R8 not empty", 64'({hi_empty, lo_empty}), 64'b00);
        push(hit_w(22'h3ABCD));
        chk(lo_ovf, "R5 lo overflow", 64'(lo_ovf), 64'd1);
        for (int k = 0; k < 17; k++)
            pop_both(base + 22'(k * 257 + 1), base, (k < 9), "R4 drain");
        @(negedge clk);
        chk(hi_empty && lo_empty && !lo_valid, "R5 discarded word absent",
            64'({hi_empty, lo_empty, lo_valid}), 64'b110);
        chk(hi_ovf && lo_ovf, "R5 overflow sticky", 64'({hi_ovf, lo_ovf}), 64'b11);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule